// File: doc/BRIEF.md
# Self-Correcting Four-Stage Twisted-Ring Timing Generator

The block is a four-flip-flop twisted-ring (switch-tail) counter that walks through eight legal states. Each legal state is turned into one of eight timing strobes, and each strobe comes from a single two-input AND of state bits. Control logic uses these strobes to step through an eight-phase operation.

A plain twisted ring has a second, parasitic cycle made of the eight unused codes. Once a glitch or a bad power-up value puts the counter in that cycle, it stays there. Here the second stage takes a corrected feedback term, and this removes the parasitic cycle. Every unused code now leads into the legal ring after a bounded number of enabled clocks. A synchronous load input can place any code into the register, so the recovery paths can be exercised directly.

The state bits are called X, Y, Z and T from the first stage to the last. They map onto `state[3]`, `state[2]`, `state[1]` and `state[0]`, and the codes below are written in that order.

Top module: `johnson_timer`

## Requirements
- R1: An active-low `rst_n` forces `state` to 0000 and `timing` to 8'b0000_0001 at once, without waiting for a clock edge.
- R2: With `cnt_en` high and `load_en` low, each rising clock edge steps `state` along 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 and then back to 0000.
- R3: With `cnt_en` and `load_en` both low, `state` and `timing` keep their values across clock edges.
- R4: With `load_en` high, the next rising edge copies `load_val` into `state`. This happens whatever the value of `cnt_en`.
- R5: When the counter steps, the new bits are X = NOT T, Y = X AND (Y OR Z OR NOT T), Z = Y and T = Z, each computed from the old bits.
- R6: `timing[0]` = X'T', `timing[1]` = XY', `timing[2]` = YZ', `timing[3]` = ZT', `timing[4]` = XT, `timing[5]` = X'Y, `timing[6]` = Y'Z and `timing[7]` = Z'T. This holds for all sixteen codes.
- R7: In the k-th legal state of the R2 sequence (k from 0 to 7), exactly one timing bit is high, and that bit is `timing[k]`.
- R8: From any of the sixteen codes, the counter enters the legal ring within 8 stepping clocks. Once there, it never leaves it while stepping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Step the counter on this edge |
| load_en | input | 1 | Load `load_val` on this edge; overrides `cnt_en` |
| load_val | input | 4 | Code to load, X in bit 3 through T in bit 0 |
| state | output | 4 | Current counter code, X in bit 3 through T in bit 0 |
| timing | output | 8 | Decoded phase strobes, one-hot in legal states |

## Verification
The checker assumes that `cnt_en` and `load_en` are ordinary synchronous levels that are stable at each rising edge. It also assumes that `load_val` may be any code, including the eight illegal ones. The ring-closure and one-hot properties hold only once the state is legal, so the checker does not assume the counter starts legal. Its recovery counter allows an illegal run of at most eight stepping clocks. The bench changes every input on the falling edge. It loads each of the sixteen codes in turn and then only steps or holds, which keeps every run of illegal stepping inside that bound.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int unsigned JC_STAGES    = 4;
    localparam int unsigned JC_PHASES    = 2 * JC_STAGES;
    localparam int unsigned JC_REC_BOUND = 2 * JC_STAGES;
    localparam int unsigned JC_RUN_W     = $clog2(JC_REC_BOUND + 2);

    typedef logic [JC_STAGES-1:0] jc_state_t;
    typedef logic [JC_PHASES-1:0] jc_phase_t;

    typedef struct packed {
        jc_state_t state;
    } jc_regs_t;

    // A legal twisted-ring code has at most one place where neighbouring
    // stages differ.
    function automatic logic jc_is_legal(jc_state_t s);
        int unsigned edges;
        edges = 0;
        for (int j = 0; j < int'(JC_STAGES) - 1; j++) begin
            if (s[j] != s[j+1]) edges++;
        end
        return edges <= 1;
    endfunction

endpackage

// File: rtl/jc_next.sv
module jc_next #(
    parameter int unsigned STAGES = jc_pkg::JC_STAGES
) (
    input  logic [STAGES-1:0] cur_q,
    input  logic              step_en,
    input  logic              load_en,
    input  logic [STAGES-1:0] load_val,
    output logic [STAGES-1:0] state_d
);

    localparam int unsigned FIRST  = STAGES - 1;
    localparam int unsigned SECOND = STAGES - 2;
    localparam int unsigned THIRD  = STAGES - 3;
    localparam int unsigned LAST   = 0;

    logic [STAGES-1:0] stepped;

    // Shift one stage towards the tail, invert on the wrap, and gate the
    // second stage so the parasitic cycle cannot sustain itself.
    always_comb begin
        stepped         = '0;
        stepped[FIRST]  = ~cur_q[LAST];
        stepped[SECOND] = cur_q[FIRST] &
                          (cur_q[SECOND] | cur_q[THIRD] | ~cur_q[LAST]);
        for (int j = 0; j < int'(SECOND); j++) begin
            stepped[j] = cur_q[j+1];
        end
    end

    always_comb begin
        if (load_en) begin
            state_d = load_val;
        end else if (step_en) begin
            state_d = stepped;
        end else begin
            state_d = cur_q;
        end
    end

endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
    parameter int unsigned STAGES = jc_pkg::JC_STAGES,
    localparam int unsigned PHASES = 2 * STAGES
) (
    input  logic [STAGES-1:0] state_q,
    output logic [PHASES-1:0] timing
);

    // Stage j sits at bit STAGES-1-j; each phase needs one two-input AND.
    for (genvar i = 0; i < PHASES; i++) begin : g_phase
        if (i == 0) begin : g_all_zero
            assign timing[i] = ~state_q[STAGES-1] & ~state_q[0];
        end else if (i < STAGES) begin : g_fill
            assign timing[i] = state_q[STAGES-i] & ~state_q[STAGES-1-i];
        end else if (i == STAGES) begin : g_all_one
            assign timing[i] = state_q[STAGES-1] & state_q[0];
        end else begin : g_drain
            assign timing[i] = ~state_q[2*STAGES-i] & state_q[2*STAGES-1-i];
        end
    end

endmodule

// File: rtl/johnson_timer.sv
module johnson_timer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    input  logic       load_en,
    input  logic [3:0] load_val,
    output logic [3:0] state,
    output logic [7:0] timing
);

    import jc_pkg::*;

    jc_regs_t  regs_d;
    jc_regs_t  regs_q;
    jc_state_t state_d;

    jc_next #(.STAGES(JC_STAGES)) u_next (
        .cur_q    (regs_q.state),
        .step_en  (cnt_en),
        .load_en  (load_en),
        .load_val (load_val),
        .state_d  (state_d)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    jc_decode #(.STAGES(JC_STAGES)) u_dec (
        .state_q (regs_q.state),
        .timing  (timing)
    );

    assign state = regs_q.state;

endmodule

// File: rtl/jc_checker.sv
module jc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic       load_en,
    input logic [3:0] load_val,
    input logic [3:0] state,
    input logic [7:0] timing
);

    import jc_pkg::*;

    logic [JC_RUN_W-1:0] bad_run_q;

    // Length of the current run of stepping clocks spent in illegal codes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_run_q <= '0;
        end else if (load_en || jc_is_legal(state)) begin
            bad_run_q <= '0;
        end else if (cnt_en && bad_run_q <= JC_RUN_W'(JC_REC_BOUND)) begin
            bad_run_q <= bad_run_q + 1'b1;
        end
    end

    p_ring_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !load_en && jc_is_legal(state)) |=> jc_is_legal(state));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load_en) |=> ($stable(state) && $stable(timing)));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state == $past(load_val)));

    p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !load_en) |=> ((state[3] == !$past(state[0])) &&
                                  (state[1] == $past(state[2])) &&
                                  (state[0] == $past(state[1]))));

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jc_is_legal(state) |-> ($countones(timing) == 1));

    p_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_run_q <= JC_RUN_W'(JC_REC_BOUND));

endmodule

bind johnson_timer jc_checker u_jc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .load_en  (load_en),
    .load_val (load_val),
    .state    (state),
    .timing   (timing)
);

// File: tb/tb_johnson_timer.sv
`timescale 1ns/1ps
module tb_johnson_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_en;
    logic       load_en;
    logic [3:0] load_val;
    logic [3:0] state;
    logic [7:0] timing;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    johnson_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .load_en  (load_en),
        .load_val (load_val),
        .state    (state),
        .timing   (timing)
    );

    // k-th legal code: k leading ones for k<=4, then ones drain from X.
    function automatic logic [3:0] seq_code(int k);
        if (k <= 4) return 4'((5'h1F << (4 - k)) & 5'h0F);
        return 4'(4'hF >> (k - 4));
    endfunction

    function automatic logic legal(logic [3:0] s);
        for (int k = 0; k < 8; k++) if (seq_code(k) == s) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [3:0] model_step(logic [3:0] s);
        logic x, y, z, t;
        {x, y, z, t} = s;
        return {~t, x & (y | z | ~t), y, z};
    endfunction

    function automatic logic [7:0] model_dec(logic [3:0] s);
        logic x, y, z, t;
        {x, y, z, t} = s;
        return {~z & t, ~y & z, ~x & y, x & t, z & ~t, y & ~z, x & ~y, ~x & ~t};
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [3:0] hold_s;
        logic [7:0] hold_t;
        rst_n = 1'b0; cnt_en = 1'b0; load_en = 1'b0; load_val = '0;
        repeat (3) @(negedge clk);
        check(state == 4'b0000, "R1 reset state", {4'b0, state}, 8'h00);
        check(timing == 8'h01, "R1 reset timing", timing, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R6/R7: two full laps of the legal ring
        cnt_en = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            check(state == seq_code(i % 8), "R2 sequence", {4'b0, state}, {4'b0, seq_code(i % 8)});
            check(timing == 8'(1 << (i % 8)), "R7 one-hot phase", timing, 8'(1 << (i % 8)));
            check(timing == model_dec(state), "R6 decode", timing, model_dec(state));
        end

        // R3: hold with enable low
        cnt_en = 1'b0;
        @(negedge clk);
        hold_s = state; hold_t = timing;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(state == hold_s, "R3 hold state", {4'b0, state}, {4'b0, hold_s});
            check(timing == hold_t, "R3 hold timing", timing, hold_t);
        end

        // R4/R5/R6/R8: every code as a starting point
        for (int s = 0; s < 16; s++) begin
            logic [3:0] cur;
            logic       reached;
            int         steps;
            cnt_en = 1'b0; load_en = 1'b1; load_val = 4'(s);
            @(negedge clk);
            load_en = 1'b0;
            check(state == 4'(s), "R4 load", {4'b0, state}, 8'(s));
            check(timing == model_dec(4'(s)), "R6 decode all codes", timing, model_dec(4'(s)));
            cur = 4'(s);
            reached = legal(cur);
            steps = 0;
            cnt_en = 1'b1;
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                check(state == model_step(cur), "R5 next-state", {4'b0, state}, {4'b0, model_step(cur)});
                if (reached)
                    check(legal(state), "R8 stays legal", {4'b0, state}, {4'b0, model_step(cur)});
                cur = model_step(cur);
                if (!reached && legal(cur)) begin
                    reached = 1'b1;
                    steps = k;
                end
            end
            check(reached && steps <= 8, "R8 recovery bound", 8'(steps), 8'd8);
        end

        // R4: load wins over count
        cnt_en = 1'b1; load_en = 1'b1; load_val = 4'b0110;
        @(negedge clk);
        load_en = 1'b0;
        check(state == 4'b0110, "R4 load priority", {4'b0, state}, 8'h06);

        // R1: asynchronous reset between edges
        #1 rst_n = 1'b0;
        #0.5;
        check(state == 4'b0000, "R1 async reset state", {4'b0, state}, 8'h00);
        check(timing == 8'h01, "R1 async reset timing", timing, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;
        cnt_en = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule